// File: doc/BRIEF.md
# Five-State Toggle-Cell Sequence Counter

This block is a synchronous three-bit counter that does not count in binary. It walks a fixed loop of five codes: 000, 100, 111, 010, 011, and then 000 again. Each state bit is stored in its own toggle cell. All three cells share one clock. A combinational decoder reads the present state and works out, for each bit, whether that bit must flip on the next rising edge to reach the next code in the loop.

The five states have these names. ST_HOME is 000, ST_LEAD is 100, ST_FULL is 111, ST_MID is 010 and ST_TAIL is 011. The transitions are HOME→LEAD, LEAD→FULL, FULL→MID, MID→TAIL and TAIL→HOME. The decoder produces these flip vectors, written MSB first:

| Transition | Flip vector |
|---|---|
| HOME→LEAD | 100 |
| LEAD→FULL | 011 |
| FULL→MID | 101 |
| MID→TAIL | 001 |
| TAIL→HOME | 011 |

The codes 001, 101 and 110 are outside the loop. For each of them the decoder flips exactly the bits that are 1, so the counter always lands on ST_HOME and cannot lock up.

The count advances only while the active-high enable is asserted. A synchronous active-low reset overrides everything else.

Top module: `seqtog_counter`

## Requirements
- R1: When rst_n is 0 at a rising clock edge, q becomes 000 after that edge. This holds whatever the value of en.
- R2: With rst_n=1 and en=1, state 000 is followed by 100 on the next rising edge.
- R3: With rst_n=1 and en=1, state 100 is followed by 111 on the next rising edge.
- R4: With rst_n=1 and en=1, state 111 is followed by 010 on the next rising edge.
- R5: With rst_n=1 and en=1, state 010 is followed by 011 on the next rising edge.
- R6: With rst_n=1 and en=1, state 011 is followed by 000 on the next rising edge.
- R7: With rst_n=1 and en=1, each of the unused codes 001, 101 and 110 is followed by 000 on the next rising edge.
- R8: With rst_n=1 and en=0, q keeps its value across the edge. This includes the case where q holds an unused code.
- R9: The leftmost digit of each state code is q[2] and the rightmost is q[0]. For example, state 100 appears as q[2]=1 and q[1:0]=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; every state bit updates on its rising edge |
| rst_n | input | 1 | Synchronous clear to 000, active low |
| en | input | 1 | Count enable, active high; when it is 0 the state holds |
| q | output | 3 | Present state, with q[2] as the most significant digit |

## Verification
Two functions can act on the same edge. One is the synchronous clear. The other is an enabled step, which on its own would move the state to a non-zero successor.

The bench provokes this collision in a directed way: it drives rst_n low with en high while the counter sits in ST_FULL. It also provokes it in the random phase, where reset pulses land on arbitrary states with the enable in either value.

After each such edge, the bench reference model, which gives reset priority over stepping, is compared with q. A 000 result counts as correct. Any successor code counts as a miscompare against R1.

// File: rtl/seqtog_pkg.sv
`timescale 1ns/1ps
package seqtog_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_HOME = 3'b000,
        ST_LEAD = 3'b100,
        ST_FULL = 3'b111,
        ST_MID  = 3'b010,
        ST_TAIL = 3'b011
    } cyc_state_e;

    // Flip masks that carry each loop state to its successor
    localparam logic [STATE_W-1:0] FLIP_HOME = 3'b100;
    localparam logic [STATE_W-1:0] FLIP_LEAD = 3'b011;
    localparam logic [STATE_W-1:0] FLIP_FULL = 3'b101;
    localparam logic [STATE_W-1:0] FLIP_MID  = 3'b001;
    localparam logic [STATE_W-1:0] FLIP_TAIL = 3'b011;

endpackage

// File: rtl/seqtog_tcell.sv
`timescale 1ns/1ps
module seqtog_tcell (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic bit_o
);

    logic bit_q;

    // One storage bit: clear on reset, invert when flip is set, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else if (flip) begin
            bit_q <= ~bit_q;
        end
    end

    assign bit_o = bit_q;

endmodule

// File: rtl/seqtog_flip_dec.sv
`timescale 1ns/1ps
module seqtog_flip_dec
    import seqtog_pkg::*;
(
    input  logic [STATE_W-1:0] cur,
    input  logic               en,
    output logic [STATE_W-1:0] flip
);

    always_comb begin
        flip = '0;
        if (en) begin
            unique case (cyc_state_e'(cur))
                ST_HOME: flip = FLIP_HOME;
                ST_LEAD: flip = FLIP_LEAD;
                ST_FULL: flip = FLIP_FULL;
                ST_MID:  flip = FLIP_MID;
                ST_TAIL: flip = FLIP_TAIL;
                // Off-loop code: flip every set bit so the result is ST_HOME
                default: flip = cur;
            endcase
        end
    end

endmodule

// File: rtl/seqtog_counter.sv
`timescale 1ns/1ps
module seqtog_counter
    import seqtog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    output logic [STATE_W-1:0] q
);

    logic [STATE_W-1:0] state_bits;
    logic [STATE_W-1:0] flip_vec;

    seqtog_flip_dec u_dec (
        .cur  (state_bits),
        .en   (en),
        .flip (flip_vec)
    );

    // State register: one toggle cell per bit, all on the shared clock
    genvar gi;
    generate
        for (gi = 0; gi < STATE_W; gi++) begin : g_cell
            seqtog_tcell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .flip  (flip_vec[gi]),
                .bit_o (state_bits[gi])
            );
        end
    endgenerate

    // Output process
    always_comb begin
        q = state_bits;
    end

endmodule

// File: rtl/seqtog_counter_chk.sv
`timescale 1ns/1ps
module seqtog_counter_chk
    import seqtog_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic [STATE_W-1:0] q
);

    logic past_valid = 1'b0;
    always_ff @(posedge clk) past_valid <= 1'b1;

    a_r1_sync_clear: assert property (@(posedge clk)
        past_valid && !rst_n |=> q == 3'b000)
        else $error("R1: q not cleared after reset edge");

    a_r2_home_to_lead: assert property (@(posedge clk) disable iff (!rst_n)
        en && q == 3'b000 |=> q == 3'b100)
        else $error("R2: bad successor of 000");

    a_r3_lead_to_full: assert property (@(posedge clk) disable iff (!rst_n)
        en && q == 3'b100 |=> q == 3'b111)
        else $error("R3: bad successor of 100");

    a_r4_full_to_mid: assert property (@(posedge clk) disable iff (!rst_n)
        en && q == 3'b111 |=> q == 3'b010)
        else $error("R4: bad successor of 111");

    a_r5_mid_to_tail: assert property (@(posedge clk) disable iff (!rst_n)
        en && q == 3'b010 |=> q == 3'b011)
        else $error("R5: bad successor of 010");

    a_r6_tail_to_home: assert property (@(posedge clk) disable iff (!rst_n)
        en && q == 3'b011 |=> q == 3'b000)
        else $error("R6: bad successor of 011");

    a_r7_unused_recover: assert property (@(posedge clk) disable iff (!rst_n)
        en && (q == 3'b001 || q == 3'b101 || q == 3'b110) |=> q == 3'b000)
        else $error("R7: unused code did not recover");

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q))
        else $error("R8: state moved while disabled");

endmodule

bind seqtog_counter seqtog_counter_chk u_chk (.*);

// File: tb/seqtog_counter_tb_top.sv
`timescale 1ns/1ps
module seqtog_counter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] q;
    logic [2:0] exp_q = 3'b000;
    logic [2:0] force_code = 3'b000;
    int         n_checks = 0;
    int         n_fails = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    seqtog_counter dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .q     (q)
    );

    function automatic logic [2:0] ref_next(logic [2:0] s, logic e, logic r);
        if (!r) return 3'b000;
        if (!e) return s;
        case (s)
            3'b000:  return 3'b100;
            3'b100:  return 3'b111;
            3'b111:  return 3'b010;
            3'b010:  return 3'b011;
            3'b011:  return 3'b000;
            default: return 3'b000;
        endcase
    endfunction

    function automatic string ref_tag(logic [2:0] s, logic e, logic r);
        if (!r) return "R1";
        if (!e) return "R8";
        case (s)
            3'b000:  return "R2";
            3'b100:  return "R3";
            3'b111:  return "R4";
            3'b010:  return "R5";
            3'b011:  return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(logic [2:0] act, logic [2:0] expv, string tag);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s: q=%b expected %b at %0t", tag, act, expv, $time);
        end
    endtask

    // Drive at the negedge, step one edge, compare at the following negedge
    task automatic apply(logic e, logic r);
        string tag;
        en = e;
        rst_n = r;
        tag = ref_tag(exp_q, e, r);
        exp_q = ref_next(exp_q, e, r);
        @(posedge clk);
        @(negedge clk);
        check(q, exp_q, tag);
    endtask

    task automatic inject(logic [2:0] code);
        force_code = code;
        force dut_i.g_cell[0].u_cell.bit_q = force_code[0];
        force dut_i.g_cell[1].u_cell.bit_q = force_code[1];
        force dut_i.g_cell[2].u_cell.bit_q = force_code[2];
        #1;
        release dut_i.g_cell[0].u_cell.bit_q;
        release dut_i.g_cell[1].u_cell.bit_q;
        release dut_i.g_cell[2].u_cell.bit_q;
        exp_q = code;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(q, 3'b000, "R1 reset state");

        // Walk the loop twice; R9: after 000 the only set bit is q[2]
        for (int k = 0; k < 10; k++) begin
            apply(1'b1, 1'b1);
            if (k == 0) begin
                check({q[2], q[1:0] == 2'b00}, 2'b11, "R9 bit order");
            end
        end

        // Hold in ST_LEAD with the enable low
        apply(1'b1, 1'b1);
        for (int k = 0; k < 3; k++) apply(1'b0, 1'b1);
        apply(1'b1, 1'b1);

        // Reset colliding with an enabled step from ST_FULL
        check(q, 3'b111, "R4 setup");
        apply(1'b1, 1'b0);

        // Unused codes: hold while disabled, then recover
        for (int c = 0; c < 3; c++) begin
            logic [2:0] code;
            code = (c == 0) ? 3'b001 : (c == 1) ? 3'b101 : 3'b110;
            apply(1'b0, 1'b1);
            $assertoff;
            inject(code);
            check(q, code, "R7 inject");
            apply(1'b0, 1'b1);
            apply(1'b1, 1'b1);
            #1;
            $asserton;
        end

        // Constrained random phase
        for (int k = 0; k < 3000; k++) begin
            apply(($urandom % 4) != 0, ($urandom % 16) != 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run hung, actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule